// File: doc/BRIEF.md
# Watchdog Timer with Encoded Period

This block is a watchdog whose timeout comes from a single byte-wide control register. The register packs a five-bit multiplier, a two-bit resolution code and a steering bit. A one-cycle tick input at 16 Hz is the time base, so the timeout is expressed in sixteenths of a second. Software keeps the watchdog alive by writing the register, or just by reading it. Either access reloads the countdown from the full period.

When the countdown runs out, the block sets a sticky expired flag and takes one of two actions, chosen by the steering bit. With the bit set, it raises a one-cycle system reset request. It also clears the control register to zero and pulses a clear output that drops the century-enable bit held in a neighbouring register. With the bit clear, it raises a one-cycle interrupt pulse instead. After a timeout the counter stays idle until software touches the register again.

Top module: `wdog_encoded_top`

## Requirements
- R1: The timeout, counted in ticks, is M × 4^E. M is control bits 6:2 and E is control bits 1:0, so the value 0x0D gives 12 ticks and 0x7F gives 1984 ticks. The timeout fires on the tick that ends that many ticks after the restart.
- R2: A period of zero stops the watchdog and no timeout ever occurs. This covers a control value of 0x00, and also any value whose bits 6:2 are zero, such as 0x03.
- R3: A write stores the byte, which then reads back on `ctrl_rdata`, and restarts the countdown from the full period of the new value.
- R4: A read strobe restarts the countdown from the full period of the stored value.
- R5: Any restart, by write or by read, clears the expired flag.
- R6: A timeout sets the expired flag, and the flag holds until the next restart.
- R7: A timeout with control bit 7 set does three things. It raises `sys_rst_req` for exactly one cycle, raises `century_clr` for that same cycle, and clears the control register to 0x00. No interrupt pulse is raised.
- R8: A timeout with control bit 7 clear raises `wdog_irq` for exactly one cycle. No reset request is raised.
- R9: After a timeout, further ticks cause no further timeout until a restart.
- R10: The count drops by one per tick. A restart in the same cycle as a tick wins, so the count starts from the full period and that tick does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data |
| ctrl_rd | input | 1 | Control register read strobe (restarts countdown) |
| ctrl_rdata | output | 8 | Stored control register value |
| tick | input | 1 | One-cycle 16 Hz time-base pulse |
| wdog_irq | output | 1 | One-cycle interrupt pulse on timeout |
| sys_rst_req | output | 1 | One-cycle system reset request on timeout |
| century_clr | output | 1 | One-cycle clear for the external century-enable bit |
| wdog_expired | output | 1 | Sticky watchdog-expired flag |

## Verification
The bench builds the block with its default parameters: a five-bit multiplier and a two-bit resolution code, which give an eleven-bit counter. Ticks are driven every other clock rather than at 16 Hz. This keeps even the largest encoded period of 1984 ticks within a short run, so the top multiplier and the top resolution code are both exercised to expiry. The zero-multiplier encodings, a restart colliding with a tick, and both steering outcomes are reached directly with these values.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    WD_ACT_NONE  = 2'd0,
    WD_ACT_IRQ   = 2'd1,
    WD_ACT_RESET = 2'd2
  } wd_action_e;

  function automatic wd_action_e wd_pick_action(input logic fire, input logic steer);
    wd_action_e a;
    a = WD_ACT_NONE;
    if (fire) a = steer ? WD_ACT_RESET : WD_ACT_IRQ;
    return a;
  endfunction

endpackage

// File: rtl/wdog_period_decode.sv
module wdog_period_decode #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  parameter int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1)
) (
  input  logic [MULT_W-1:0] mult,
  input  logic [RES_W-1:0]  res,
  output logic [CNT_W-1:0]  period,
  output logic              period_zero
);

  localparam int NUM_RES = 1 << RES_W;

  logic [CNT_W-1:0] cand [NUM_RES];

  // one scaled candidate per resolution code: mult * 4^r
  for (genvar r = 0; r < NUM_RES; r++) begin : g_scale
    assign cand[r] = CNT_W'(mult) << (2 * r);
  end

  always_comb begin
    period = '0;
    for (int r = 0; r < NUM_RES; r++) begin
      if (res == RES_W'(r)) period = cand[r];
    end
  end

  assign period_zero = (mult == '0);

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire,
  output logic             running
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             cnt_en;
  logic             last_tick;

  assign last_tick = (cnt_q == CNT_W'(1));
  assign expire    = tick && run_q && last_tick && !restart;
  assign cnt_en    = restart || (tick && run_q);

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (restart) begin
      cnt_d = load_val;
      run_d = (load_val != '0);
    end else if (tick && run_q) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (last_tick) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign running = run_q;

  // R10
  decrement_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run_q && !restart && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R10
  restart_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && load_val != '0) |=> (run_q && cnt_q == $past(load_val)));

  // R2
  zero_period_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && load_val == '0) |=> !run_q);

  // R9
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !restart) |=> !run_q);

endmodule

// File: rtl/wdog_response.sv
module wdog_response
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic expire,
  input  logic steer,
  output logic clear_ctrl,
  output logic irq_pulse,
  output logic rst_req_pulse,
  output logic century_clr,
  output logic expired_flag
);

  wd_action_e act;
  logic       irq_d, rst_d, flag_d;
  logic       irq_q, rst_q, flag_q;

  assign act        = wd_pick_action(expire, steer);
  assign clear_ctrl = (act == WD_ACT_RESET);

  always_comb begin
    irq_d  = (act == WD_ACT_IRQ);
    rst_d  = (act == WD_ACT_RESET);
    flag_d = flag_q;
    if (restart)     flag_d = 1'b0;
    else if (expire) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      rst_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      rst_q  <= rst_d;
      flag_q <= flag_d;
    end
  end

  assign irq_pulse     = irq_q;
  assign rst_req_pulse = rst_q;
  assign century_clr   = rst_q;
  assign expired_flag  = flag_q;

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R7
  rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> !rst_q);

  // R7
  actions_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_q && rst_q));

  // R5
  restart_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !flag_q);

  // R6
  expire_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_q);

endmodule

// File: rtl/wdog_encoded_top.sv
module wdog_encoded_top #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ctrl_wr,
  input  logic [MULT_W+RES_W:0]          ctrl_wdata,
  input  logic                           ctrl_rd,
  output logic [MULT_W+RES_W:0]          ctrl_rdata,
  input  logic                           tick,
  output logic                           wdog_irq,
  output logic                           sys_rst_req,
  output logic                           century_clr,
  output logic                           wdog_expired
);

  localparam int CTRL_W    = MULT_W + RES_W + 1;
  localparam int STEER_BIT = CTRL_W - 1;
  localparam int CNT_W     = MULT_W + 2 * ((1 << RES_W) - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [CTRL_W-1:0] ctrl_q, ctrl_d, src;
  logic              ctrl_en;
  logic              restart;
  logic              clear_ctrl;
  logic              expire;
  logic              running;
  logic              period_zero;
  logic [CNT_W-1:0]  period;
  logic [CNT_W-1:0]  load_val;

  assign restart = ctrl_wr || ctrl_rd;
  assign src     = ctrl_wr ? ctrl_wdata : ctrl_q;

  wdog_period_decode #(
    .MULT_W (MULT_W),
    .RES_W  (RES_W),
    .CNT_W  (CNT_W)
  ) u_decode (
    .mult        (src[RES_W +: MULT_W]),
    .res         (src[RES_W-1:0]),
    .period      (period),
    .period_zero (period_zero)
  );

  assign load_val = period_zero ? '0 : period;

  wdog_countdown #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .restart  (restart),
    .load_val (load_val),
    .tick     (tick),
    .expire   (expire),
    .running  (running)
  );

  wdog_response u_resp (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .restart       (restart),
    .expire        (expire),
    .steer         (ctrl_q[STEER_BIT]),
    .clear_ctrl    (clear_ctrl),
    .irq_pulse     (wdog_irq),
    .rst_req_pulse (sys_rst_req),
    .century_clr   (century_clr),
    .expired_flag  (wdog_expired)
  );

  assign ctrl_en = ctrl_wr || clear_ctrl;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr)         ctrl_d = ctrl_wdata;
    else if (clear_ctrl) ctrl_d = '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  assign ctrl_rdata = ctrl_q;

  // R7
  ctrl_cleared_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    sys_rst_req |-> (ctrl_q == '0));

  // R3
  write_stored_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctrl_wr |=> (ctrl_q == $past(ctrl_wdata)));

  // R9
  no_fire_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !running |-> !expire);

endmodule

// File: tb/wdog_encoded_top_bench.sv
module wdog_encoded_top_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctrl_wr, ctrl_rd, tick;
  logic [7:0] ctrl_wdata;
  logic [7:0] ctrl_rdata;
  logic       wdog_irq, sys_rst_req, century_clr, wdog_expired;

  int errors = 0;
  int checks = 0;
  int irq_cnt = 0, rst_cnt = 0, clr_cnt = 0;

  always #2.5 clk = ~clk;

  wdog_encoded_top u_wdog_encoded_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_wr      (ctrl_wr),
    .ctrl_wdata   (ctrl_wdata),
    .ctrl_rd      (ctrl_rd),
    .ctrl_rdata   (ctrl_rdata),
    .tick         (tick),
    .wdog_irq     (wdog_irq),
    .sys_rst_req  (sys_rst_req),
    .century_clr  (century_clr),
    .wdog_expired (wdog_expired)
  );

  always @(negedge clk) begin
    if (wdog_irq)    irq_cnt++;
    if (sys_rst_req) rst_cnt++;
    if (century_clr) clr_cnt++;
  end

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    settle();
  endtask

  task automatic wr(input logic [7:0] v, input logic with_tick);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v; tick = with_tick;
    @(negedge clk); ctrl_wr = 1'b0; tick = 1'b0;
    settle();
  endtask

  task automatic rd();
    @(negedge clk); ctrl_rd = 1'b1;
    @(negedge clk); ctrl_rd = 1'b0;
    settle();
  endtask

  task automatic clear_counts();
    irq_cnt = 0; rst_cnt = 0; clr_cnt = 0;
  endtask

  task automatic t_reset();
    check("reset rdata", ctrl_rdata, 0);
    check("reset irq",   wdog_irq, 0);
    check("reset rst",   sys_rst_req, 0);
    check("reset flag",  wdog_expired, 0);
  endtask

  // R1 R8 R6 R9: period exact, irq once, flag set, then idle
  task automatic t_period(input logic [7:0] v, input int n);
    clear_counts();
    wr(v, 1'b0);
    ticks(n - 1);
    check("R1 no early timeout", irq_cnt, 0);
    check("R6 flag clear before", wdog_expired, 0);
    ticks(1);
    check("R1 R8 irq on last tick", irq_cnt, 1);
    check("R8 no reset request", rst_cnt, 0);
    check("R6 flag set", wdog_expired, 1);
    ticks(n + 3);
    check("R9 idle after timeout", irq_cnt, 1);
  endtask

  // R2: zero periods never expire
  task automatic t_zero(input logic [7:0] v);
    clear_counts();
    wr(v, 1'b0);
    check("R3 readback", ctrl_rdata, v);
    ticks(100);
    check("R2 no irq", irq_cnt, 0);
    check("R2 no reset", rst_cnt, 0);
    check("R2 flag stays clear", wdog_expired, 0);
  endtask

  // R3 R4: mid-count restart by write or read
  task automatic t_kick(input logic by_read);
    clear_counts();
    wr(8'h0D, 1'b0);
    ticks(8);
    if (by_read) rd(); else wr(8'h0D, 1'b0);
    ticks(11);
    check(by_read ? "R4 read restart full" : "R3 write restart full", irq_cnt, 0);
    ticks(1);
    check(by_read ? "R4 fires after full" : "R3 fires after full", irq_cnt, 1);
  endtask

  // R5 R4: read after timeout clears flag and re-arms from stored value
  task automatic t_flag_clear();
    clear_counts();
    rd();
    check("R5 read clears flag", wdog_expired, 0);
    check("R3 stored value kept", ctrl_rdata, 8'h0D);
    ticks(12);
    check("R4 rearmed by read", irq_cnt, 1);
    wr(8'h0D, 1'b0);
    check("R5 write clears flag", wdog_expired, 0);
  endtask

  // R7: steered timeout
  task automatic t_steer();
    clear_counts();
    wr(8'h85, 1'b0);
    ticks(3);
    check("R7 no early reset", rst_cnt, 0);
    ticks(1);
    check("R7 reset request once", rst_cnt, 1);
    check("R7 century clear once", clr_cnt, 1);
    check("R7 no irq", irq_cnt, 0);
    check("R7 control cleared", ctrl_rdata, 0);
    check("R6 flag on reset timeout", wdog_expired, 1);
  endtask

  // R10: restart coinciding with tick
  task automatic t_collide();
    clear_counts();
    wr(8'h0D, 1'b1);
    ticks(11);
    check("R10 colliding tick not counted", irq_cnt, 0);
    ticks(1);
    check("R10 fires after full period", irq_cnt, 1);
  endtask

  initial begin
    rst_n = 1'b0; ctrl_wr = 1'b0; ctrl_rd = 1'b0; tick = 1'b0; ctrl_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_period(8'h0D, 12);
    t_flag_clear();
    t_period(8'h0A, 32);
    t_period(8'h07, 64);
    t_zero(8'h00);
    t_zero(8'h03);
    t_kick(1'b0);
    t_kick(1'b1);
    t_collide();
    t_steer();
    t_period(8'h7F, 1984);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule